// File: doc/BRIEF.md
# Configurable 16-bit Timer/Counter

This block is a 16-bit up-counter kept as a low byte and a high byte. It advances either from an internal tick that fires once every four system clocks (timer mode) or from rising edges on one of two external clock pins (counter mode). Both sources pass through a shared prescaler that divides by 1, 2, 4 or 8. In counter mode the prescaler output may be handed to the count directly, or first passed through a two-stage synchronizer with rising-edge detection.

A sleep input models low-power operation. The internal tick stops, and the synchronizer stops with it. The prescaler keeps counting external edges, and the unsynchronized counter path keeps counting. Software loads either byte through a shared data bus. A sticky flag records each rollover from all ones to zero until it is cleared.

All logic runs on the system clock. External pins are sampled once and edge-detected, and the prescaler counts those detected edges.

Top module: `tmr16_top`

## Requirements
- R1: After reset the count reads 0x0000 and the overflow flag reads 0.
- R2: With `src_ext`=0 and `run_en`=1 the count advances once every four system clocks at prescale code 00, and the value of `no_sync` makes no difference.
- R3: With `src_ext`=1 the count advances on rising edges of `ext_pin_b` when `pin_sel`=1 and of `ext_pin_a` when `pin_sel`=0. Edges on the unselected pin have no effect.
- R4: The prescale code `ps_code` divides by 1, 2, 4 or 8 for codes 00, 01, 10 or 11. After the prescaler is cleared, code c≥1 gives its first increment on edge 2^(c-1), and then one increment every 2^c edges.
- R5: In synchronized counter mode (`src_ext`=1, `no_sync`=0), each rising edge of the prescaler output produces exactly one increment.
- R6: In synchronized counter mode with `sleep`=1 the count does not change, but the prescaler keeps counting external edges. A prescaler output that went high during sleep gives one increment after `sleep` returns to 0.
- R7: In unsynchronized counter mode (`no_sync`=1) the count keeps advancing while `sleep`=1.
- R8: In timer mode the count does not change while `sleep`=1.
- R9: With `run_en`=0 the count does not change in any mode.
- R10: `wr_lo` loads `wdata` into bits 7:0 and `wr_hi` loads it into bits 15:8. A write takes priority over an increment in the same cycle. Any write, or any change of `ps_code`, clears the prescaler.
- R11: `ovf_flag` is set when the count steps from 0xFFFF to 0x0000, stays set until `clr_ovf`, and a rollover in the same cycle as `clr_ovf` leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Gates every increment of the count |
| src_ext | input | 1 | 0: internal tick, 1: external pin edges |
| pin_sel | input | 1 | External pin choice: 1 selects ext_pin_b, 0 selects ext_pin_a |
| no_sync | input | 1 | 1 bypasses the synchronizer in counter mode |
| ps_code | input | 2 | Prescale code: 00 /1, 01 /2, 10 /4, 11 /8 |
| sleep | input | 1 | Low-power state |
| ext_pin_a | input | 1 | External clock pin A |
| ext_pin_b | input | 1 | External clock pin B |
| wr_lo | input | 1 | Load wdata into the low byte |
| wr_hi | input | 1 | Load wdata into the high byte |
| wdata | input | 8 | Write data for the count bytes |
| clr_ovf | input | 1 | Clear the overflow flag |
| count_lo | output | 8 | Count bits 7:0 |
| count_hi | output | 8 | Count bits 15:8 |
| ovf_flag | output | 1 | Sticky rollover flag |

## Verification
Fixed windows of the internal tick are compared under both prescale codes and both sync settings; equal deltas show that the tick rate is right and that the sync control is ignored in timer mode. Random edge bursts are run with random prescale codes, pins and sync settings and compared with a closed-form count of prescaler rises. This separates the dividers from one another and the prescaler phase after a clear. Directed bursts during sleep tell the synchronized path from the unsynchronized one, and a two-edge burst at divide-by-4 shows that the prescaler kept counting. Edges timed to land in the same cycle as a write or an overflow clear expose the wrong priority.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int PS_CODE_W = 2;
  localparam int PS_CNT_W  = 3;

  // True when the next event raises the selected prescaler output bit.
  function automatic logic ps_rise(input logic [PS_CNT_W-1:0]  cnt,
                                   input logic [PS_CODE_W-1:0] code);
    logic [PS_CNT_W-1:0] mask;
    logic [PS_CNT_W-1:0] want;
    if (code == '0) return 1'b1;
    mask = (PS_CNT_W'(1) << code) - PS_CNT_W'(1);
    want = (PS_CNT_W'(1) << (code - PS_CODE_W'(1))) - PS_CNT_W'(1);
    return (cnt & mask) == want;
  endfunction

  // Level of the prescaler output: the raw sampled pin at divide-by-1.
  function automatic logic ps_level(input logic [PS_CNT_W-1:0]  cnt,
                                    input logic [PS_CODE_W-1:0] code,
                                    input logic                 raw);
    int idx;
    if (code == '0) return raw;
    idx = int'(code) - 1;
    return cnt[idx];
  endfunction
endpackage

// File: rtl/tmr16_tick_gen.sv
module tmr16_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= '0;
    else if (run) begin
      if (phase_q == LAST)   phase_q <= '0;
      else                   phase_q <= phase_q + W'(1);
    end
  end

  assign tick = run && (phase_q == LAST);

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler
  import tmr16_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt,
  input  logic                 clr,
  input  logic [PS_CODE_W-1:0] code,
  input  logic                 raw_lvl,
  output logic                 rise_pulse,
  output logic                 level
);
  logic [PS_CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (evt)  cnt_q <= cnt_q + PS_CNT_W'(1);
  end

  assign rise_pulse = evt && !clr && ps_rise(cnt_q, code);
  assign level      = ps_level(cnt_q, code, raw_lvl);

  p_div1_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0 && evt && !clr) |-> rise_pulse);
endmodule

// File: rtl/tmr16_sync_edge.sv
module tmr16_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic d,
  output logic rise
);
  logic [STAGES-1:0] stg_q;
  logic              hist_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     stg_q <= '0;
        else if (!hold) stg_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     stg_q <= '0;
        else if (!hold) stg_q <= {stg_q[STAGES-2:0], d};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hist_q <= 1'b0;
    else if (!hold) hist_q <= stg_q[STAGES-1];
  end

  assign rise = !hold && stg_q[STAGES-1] && !hist_q;

  p_no_rise_asleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !rise);
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic                 src_ext,
  input  logic                 pin_sel,
  input  logic                 no_sync,
  input  logic [PS_CODE_W-1:0] ps_code,
  input  logic                 sleep,
  input  logic                 ext_pin_a,
  input  logic                 ext_pin_b,
  input  logic                 wr_lo,
  input  logic                 wr_hi,
  input  logic [BYTE_W-1:0]    wdata,
  input  logic                 clr_ovf,
  output logic [BYTE_W-1:0]    count_lo,
  output logic [BYTE_W-1:0]    count_hi,
  output logic                 ovf_flag
);
  localparam int CNT_W = 2 * BYTE_W;

  logic                 pin_s_q, pin_h_q, ext_edge;
  logic                 int_tick, ps_evt, ps_clr, ps_pulse, ps_lvl;
  logic                 sync_rise, use_sync, inc_evt, wr_any, wrap_evt;
  logic [PS_CODE_W-1:0] code_q;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 ovf_q;

  // Sample the chosen pin and find its rising edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s_q <= 1'b0;
      pin_h_q <= 1'b0;
      code_q  <= '0;
    end else begin
      pin_s_q <= pin_sel ? ext_pin_b : ext_pin_a;
      pin_h_q <= pin_s_q;
      code_q  <= ps_code;
    end
  end
  assign ext_edge = pin_s_q && !pin_h_q;

  tmr16_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(!sleep), .tick(int_tick)
  );

  assign wr_any = wr_lo || wr_hi;
  assign ps_evt = src_ext ? ext_edge : int_tick;
  assign ps_clr = wr_any || (ps_code != code_q);

  tmr16_prescaler u_ps (
    .clk(clk), .rst_n(rst_n), .evt(ps_evt), .clr(ps_clr), .code(ps_code),
    .raw_lvl(pin_s_q), .rise_pulse(ps_pulse), .level(ps_lvl)
  );

  tmr16_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold(sleep), .d(ps_lvl), .rise(sync_rise)
  );

  assign use_sync = src_ext && !no_sync;
  assign inc_evt  = run_en && (use_sync ? sync_rise : ps_pulse);
  assign wrap_evt = inc_evt && !wr_any && (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_any) begin
      if (wr_lo) cnt_d[BYTE_W-1:0]     = wdata;
      if (wr_hi) cnt_d[CNT_W-1:BYTE_W] = wdata;
    end else if (inc_evt) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (wrap_evt)     ovf_q <= 1'b1;
      else if (clr_ovf) ovf_q <= 1'b0;
    end
  end

  assign count_lo = cnt_q[BYTE_W-1:0];
  assign count_hi = cnt_q[CNT_W-1:BYTE_W];
  assign ovf_flag = ovf_q;

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_evt && !wr_any) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_off_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_any) |=> $stable(cnt_q));
  p_sync_sleep_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && src_ext && !no_sync && !wr_any) |=> $stable(cnt_q));
  p_timer_sleep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !src_ext && !wr_any) |=> $stable(cnt_q));
  p_ovf_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag);
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);
endmodule

// File: tb/tb_tmr16_top.sv
module tb_tmr16_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0, src_ext = 1'b0, pin_sel = 1'b0, no_sync = 1'b0;
  logic [1:0] ps_code = 2'b00;
  logic       sleep = 1'b0, ext_pin_a = 1'b0, ext_pin_b = 1'b0;
  logic       wr_lo = 1'b0, wr_hi = 1'b0, clr_ovf = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] count_lo, count_hi;
  logic       ovf_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tmr16_top dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_ext(src_ext),
    .pin_sel(pin_sel), .no_sync(no_sync), .ps_code(ps_code), .sleep(sleep),
    .ext_pin_a(ext_pin_a), .ext_pin_b(ext_pin_b), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .wdata(wdata), .clr_ovf(clr_ovf), .count_lo(count_lo),
    .count_hi(count_hi), .ovf_flag(ovf_flag)
  );

  function automatic int cnt16();
    return int'({count_hi, count_lo});
  endfunction

  // Increments expected from n edges after a prescaler clear.
  function automatic int exp_incs(int n, int code);
    int got = 0;
    for (int e = 1; e <= n; e++) begin
      if (code == 0) got++;
      else if ((e % (1 << code)) == (1 << (code - 1))) got++;
    end
    return got;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(bit on, bit ext, bit sel, bit ns, int code);
    @(negedge clk);
    run_en = on; src_ext = ext; pin_sel = sel; no_sync = ns;
    ps_code = 2'(code);
    idle(6);
  endtask

  task automatic wr16(int val);
    @(negedge clk);
    wr_hi = 1'b1; wdata = 8'(val >> 8);
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b1; wdata = 8'(val);
    @(negedge clk);
    wr_lo = 1'b0;
    idle(6);
  endtask

  task automatic pulses(bit on_b, int n);
    for (int i = 0; i < n; i++) begin
      if (on_b) ext_pin_b = 1'b1; else ext_pin_a = 1'b1;
      idle(3);
      if (on_b) ext_pin_b = 1'b0; else ext_pin_a = 1'b0;
      idle(3);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd2024));
    idle(3);
    // R1: reset state
    chk("R1 count", cnt16(), 0);
    chk("R1 ovf", int'(ovf_flag), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk("R1 count after release", cnt16(), 0);

    // R2: timer mode rate, sync control ignored
    for (int ns = 0; ns < 2; ns++) begin
      cfg(1'b1, 1'b0, 1'b0, ns[0], 0);
      base = cnt16(); idle(40);
      chk("R2 timer /1", cnt16() - base, 10);
    end
    cfg(1'b1, 1'b0, 1'b0, 1'b0, 1);
    base = cnt16(); idle(80);
    chk("R4 timer /2", cnt16() - base, 10);

    // R9: disabled holds
    cfg(1'b0, 1'b0, 1'b0, 1'b0, 0);
    base = cnt16(); idle(40);
    chk("R9 off timer", cnt16() - base, 0);
    cfg(1'b0, 1'b1, 1'b0, 1'b1, 0);
    base = cnt16(); pulses(1'b0, 4); idle(6);
    chk("R9 off counter", cnt16() - base, 0);

    // R8: timer mode frozen in sleep
    cfg(1'b1, 1'b0, 1'b0, 1'b0, 0);
    @(negedge clk); sleep = 1'b1; idle(2);
    base = cnt16(); idle(40);
    chk("R8 timer sleep", cnt16() - base, 0);
    @(negedge clk); sleep = 1'b0;

    // R3: pin select
    cfg(1'b1, 1'b1, 1'b1, 1'b1, 0);
    wr16(0);
    pulses(1'b0, 5); idle(6);
    chk("R3 unselected pin A", cnt16(), 0);
    pulses(1'b1, 3); idle(6);
    chk("R3 selected pin B", cnt16(), 3);
    cfg(1'b1, 1'b1, 1'b0, 1'b0, 0);
    wr16(0);
    pulses(1'b1, 4); idle(6);
    chk("R3 unselected pin B", cnt16(), 0);
    pulses(1'b0, 2); idle(8);
    chk("R5 sync pin A", cnt16(), 2);

    // R7: unsynchronized path counts in sleep
    cfg(1'b1, 1'b1, 1'b0, 1'b1, 0);
    wr16(16'h0100);
    @(negedge clk); sleep = 1'b1;
    pulses(1'b0, 5); idle(6);
    chk("R7 unsync sleep", cnt16(), 16'h0105);
    @(negedge clk); sleep = 1'b0;

    // R6: sync path held in sleep, prescaler keeps counting (/4)
    cfg(1'b1, 1'b1, 1'b0, 1'b0, 2);
    wr16(16'h0200);
    @(negedge clk); sleep = 1'b1;
    pulses(1'b0, 2); idle(6);
    chk("R6 sync sleep hold", cnt16(), 16'h0200);
    @(negedge clk); sleep = 1'b0;
    idle(8);
    chk("R6 wake increment", cnt16(), 16'h0201);

    // R10: write clears prescaler (/8)
    cfg(1'b1, 1'b1, 1'b0, 1'b1, 3);
    wr16(16'h0010);
    pulses(1'b0, 3); idle(4);
    wr16(16'h0010);
    pulses(1'b0, 3); idle(6);
    chk("R10 write clears prescaler", cnt16(), 16'h0010);
    // R10: code change clears prescaler
    wr16(16'h0020);
    pulses(1'b0, 3); idle(4);
    @(negedge clk); ps_code = 2'd2; idle(4);
    pulses(1'b0, 2); idle(6);
    chk("R10 code change clears prescaler", cnt16(), 16'h0021);

    // R10: write wins over same-cycle increment
    cfg(1'b1, 1'b1, 1'b0, 1'b1, 0);
    wr16(16'h0030);
    @(negedge clk); ext_pin_a = 1'b1;
    @(negedge clk); wr_lo = 1'b1; wdata = 8'h55;
    @(negedge clk); wr_lo = 1'b0;
    idle(3); ext_pin_a = 1'b0; idle(4);
    chk("R10 write priority", cnt16(), 16'h0055);

    // R11: rollover, stickiness, clear, and set-beats-clear
    cfg(1'b0, 1'b0, 1'b0, 1'b0, 0);
    wr16(16'hFFFF);
    @(negedge clk); run_en = 1'b1; idle(8);
    @(negedge clk); run_en = 1'b0; idle(2);
    chk("R11 ovf set", int'(ovf_flag), 1);
    chk("R11 count wrapped hi", int'(count_hi), 0);
    idle(10);
    chk("R11 ovf sticky", int'(ovf_flag), 1);
    @(negedge clk); clr_ovf = 1'b1;
    @(negedge clk); clr_ovf = 1'b0;
    chk("R11 ovf cleared", int'(ovf_flag), 0);
    cfg(1'b1, 1'b1, 1'b0, 1'b1, 0);
    wr16(16'hFFFF);
    @(negedge clk); ext_pin_a = 1'b1;
    @(negedge clk); clr_ovf = 1'b1;
    @(negedge clk); clr_ovf = 1'b0;
    chk("R11 set beats clear", int'(ovf_flag), 1);
    chk("R11 wrap count", cnt16(), 0);
    idle(3); ext_pin_a = 1'b0; idle(4);
    @(negedge clk); clr_ovf = 1'b1;
    @(negedge clk); clr_ovf = 1'b0;

    // R4/R5: random bursts against the closed-form prescaler model
    for (int it = 0; it < 24; it++) begin
      int code = int'($urandom_range(3, 0));
      bit ns   = 1'($urandom_range(1, 0));
      bit sel  = 1'($urandom_range(1, 0));
      int n    = int'($urandom_range(20, 0));
      int st   = int'($urandom_range(16'hFF00, 0));
      cfg(1'b1, 1'b1, sel, ns, code);
      wr16(st);
      pulses(sel, n); idle(8);
      chk(ns ? "R4 random unsync" : "R5 random sync", cnt16(),
          (st + exp_incs(n, code)) & 16'hFFFF);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule